// File: doc/BRIEF.md
# Capture/Compare Timer Array

This block is a timer peripheral built around one 16-bit up-counter that advances on a qualified tick input. Six identical channels watch that counter. Each channel can grab the counter value when its input pin changes, spot the moment the counter steps onto a programmed value, flip its output pin on such a hit, or produce an 8-bit pulse-width waveform from the counter's low byte.

Every channel event, the counter's own wrap and a wrap reported by a neighbouring counter land in one sticky status register. Hardware sets these bits and software clears them. The enabled bits are merged into a single interrupt request. A CPU reaches all registers through a plain synchronous bus: a write takes effect on the clock edge that samples it, and read data appears one cycle after the read strobe.

Address map. 0x00 is the counter low byte and 0x01 the high byte; both can be read and written. 0x02 is the control register: bit 0 run, bit 1 wrap interrupt enable, bit 2 external wrap interrupt enable. 0x03 is the status register: bits 5:0 are the channel flags, bit 6 the counter wrap and bit 7 the external wrap. Channel n occupies three registers at 0x10+4n: +0 mode, +1 value low byte, +2 value high byte. Mode bits are: 7 interrupt enable, 6 comparator enable, 5 rising capture, 4 falling capture, 3 match flag enable, 2 toggle, 1:0 PWM select.

Top module: `cctimer_array`

## Requirements
- R1: After reset all mode, value, control and status registers read 00h, the counter reads 0000h, every channel output is 0 and irq is 0.
- R2: The counter goes up by exactly one for each clock cycle in which tick is 1 and the run bit (control bit 0) is 1. It holds otherwise. A write to 0x00 or 0x01 loads that byte and takes priority over a tick in the same cycle.
- R3: An increment from FFFFh to 0000h sets status bit 6.
- R4: With rising capture (mode bit 5) set, a rising edge on the channel pin sets the channel's status bit and copies the counter into the channel value register. The pin passes through a two-flop synchronizer first, so the copy happens three clock edges after the pin changes.
- R5: Falling capture (mode bit 4) does the same on a falling edge. With both bits set, either edge captures. An edge whose capture bit is clear changes neither the value nor the flag.
- R6: A compare match happens only when the comparator enable (mode bit 6) is 1 and the counter has just incremented onto the channel value. A match sets the channel's status bit only when mode bit 3 is 1. Holding at the value or loading it over the bus is not a match.
- R7: With toggle (mode bit 2) set, the channel output inverts on the clock edge after a match, whether or not bit 3 is set.
- R8: When PWM select (mode bits 1:0) is nonzero, the channel output is 1 while counter bits 7:0 are below value bits 7:0, and 0 otherwise. The high bytes play no part.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Software cannot set a bit. A hardware set in the same cycle as a clear leaves the bit set.
- R10: irq is 1 exactly when at least one status bit is set together with its enable. For a channel the enable is its mode bit 7, for bit 6 it is control bit 1, and for bit 7 it is control bit 2. A one-cycle pulse on ext_ovf sets status bit 7.
- R11: bus_rdata returns the addressed register in the cycle after bus_rd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance qualifier |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_ovf | input | 1 | Wrap pulse from a neighbouring counter |
| cap_in | input | 6 | Channel capture pins |
| cmp_out | output | 6 | Channel output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench races a software clear of a flag against a hardware capture that lands on the same edge. A design that lets the clear win would lose that event without any trace. It also checks that a counter resting on, or loaded with, the compare value does not retrigger. A level-sensitive comparator would keep toggling the output on every cycle and would flag matches that never happened. Each edge is tried against each capture-bit combination, because a swapped or ORed polarity would record edges that should be ignored. Finally, PWM is driven with counts whose high byte is nonzero, to expose a comparison that uses the full 16-bit width.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef struct packed {
    logic       irq_en;
    logic       cmp_en;
    logic       cap_rise;
    logic       cap_fall;
    logic       match_flag;
    logic       toggle;
    logic [1:0] pwm_sel;
  } chan_mode_t;

  localparam int unsigned REG_CNT_LO  = 0;
  localparam int unsigned REG_CNT_HI  = 1;
  localparam int unsigned REG_CTRL    = 2;
  localparam int unsigned REG_STAT    = 3;
  localparam int unsigned CH_BASE     = 16;
  localparam int unsigned CH_STRIDE   = 4;
  localparam int unsigned CH_MODE_OFS = 0;
  localparam int unsigned CH_VLO_OFS  = 1;
  localparam int unsigned CH_VHI_OFS  = 2;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [7:0]    ld_data_i,
  output logic [CW-1:0] cnt_o,
  output logic          step_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step_q;
  logic          inc;

  // a bus load in the same cycle takes priority over the tick
  assign inc   = run_i & tick_i & ~(ld_lo_i | ld_hi_i);
  assign ovf_o = inc & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_lo_i) cnt_d[7:0]    = ld_data_i;
    if (ld_hi_i) cnt_d[CW-1:8] = (CW-8)'(ld_data_i);
    if (inc)     cnt_d         = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      step_q <= inc;
    end
  end

  assign cnt_o  = cnt_q;
  assign step_o = step_q;

  // R3
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && tick_i) && !ld_lo_i && !ld_hi_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  chan_mode_t    mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  input  logic          pin_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [7:0]    wdata_i,
  output logic [CW-1:0] val_o,
  output logic          evt_o,
  output logic          out_o
);
  localparam int unsigned SYNC_N = 3;

  logic [SYNC_N-1:0] sync_q, sync_d;
  logic [CW-1:0]     val_q, val_d;
  logic              tgl_q, tgl_d;
  logic              rise, fall, cap, match, pwm_hi;

  // stages 0 and 1 synchronize; stage 2 holds the previous level for edge detection
  assign sync_d = {sync_q[SYNC_N-2:0], pin_i};
  assign rise   =  sync_q[1] & ~sync_q[2];
  assign fall   = ~sync_q[1] &  sync_q[2];
  assign cap    = (mode_i.cap_rise & rise) | (mode_i.cap_fall & fall);
  assign match  = mode_i.cmp_en & step_i & (cnt_i == val_q);

  always_comb begin
    val_d = val_q;
    if (wr_lo_i) val_d[7:0]    = wdata_i;
    if (wr_hi_i) val_d[CW-1:8] = (CW-8)'(wdata_i);
    if (cap)     val_d         = cnt_i;
    tgl_d = tgl_q ^ (match & mode_i.toggle);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      val_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      val_q  <= val_d;
      tgl_q  <= tgl_d;
    end
  end

  assign pwm_hi = cnt_i[7:0] < val_q[7:0];
  assign out_o  = (|mode_i.pwm_sel) ? pwm_hi : tgl_q;
  assign evt_o  = cap | (match & mode_i.match_flag);
  assign val_o  = val_q;

  // R4
  cap_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (val_q == $past(cnt_i)));

  // R7
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && mode_i.toggle) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/cct_status.sv
module cct_status #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] hw_set_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_mask_i,
  input  logic [NSRC-1:0] en_mask_i,
  output logic [NSRC-1:0] flags_o,
  output logic            irq_o
);
  logic [NSRC-1:0] flags_q, flags_d, clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;
  // a hardware set is ORed in after the clear, so it wins a same-cycle race
  assign flags_d = (flags_q & ~clr_eff) | hw_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_mask_i);

  // R9
  hw_set_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((flags_q & $past(hw_set_i)) == $past(hw_set_i)));

  // R9
  no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(hw_set_i)) == '0));
endmodule

// File: rtl/cctimer_array.sv
module cctimer_array
  import cct_pkg::*;
#(
  parameter int unsigned NCH = 6,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic           ext_ovf,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH-1:0] cmp_out,
  output logic           irq
);
  localparam int unsigned NSRC   = NCH + 2;
  localparam int unsigned OVF_B  = NCH;
  localparam int unsigned EXT_B  = NCH + 1;
  localparam int unsigned CTRL_W = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // control register: bit0 run, bit1 wrap irq enable, bit2 external wrap irq enable
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we, stat_we, cnt_lo_we, cnt_hi_we;

  assign ctrl_we   = bus_wr && (bus_addr == AW'(REG_CTRL));
  assign stat_we   = bus_wr && (bus_addr == AW'(REG_STAT));
  assign cnt_lo_we = bus_wr && (bus_addr == AW'(REG_CNT_LO));
  assign cnt_hi_we = bus_wr && (bus_addr == AW'(REG_CNT_HI));
  assign ctrl_d    = ctrl_we ? bus_wdata[CTRL_W-1:0] : ctrl_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  logic [CW-1:0] cnt;
  logic          cnt_step, cnt_ovf;

  cct_counter #(.CW(CW)) u_counter (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .run_i     (ctrl_q[0]),
    .ld_lo_i   (cnt_lo_we),
    .ld_hi_i   (cnt_hi_we),
    .ld_data_i (bus_wdata),
    .cnt_o     (cnt),
    .step_o    (cnt_step),
    .ovf_o     (cnt_ovf)
  );

  chan_mode_t    mode_q [NCH];
  logic [CW-1:0] ch_val [NCH];
  logic [NCH-1:0] ch_evt, ch_ie;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + c * CH_STRIDE;
    logic       mode_we, vlo_we, vhi_we;
    chan_mode_t mode_d;

    assign mode_we = bus_wr && (bus_addr == AW'(BASE + CH_MODE_OFS));
    assign vlo_we  = bus_wr && (bus_addr == AW'(BASE + CH_VLO_OFS));
    assign vhi_we  = bus_wr && (bus_addr == AW'(BASE + CH_VHI_OFS));
    assign mode_d  = mode_we ? chan_mode_t'(bus_wdata) : mode_q[c];

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) mode_q[c] <= '0;
      else         mode_q[c] <= mode_d;
    end

    assign ch_ie[c] = mode_q[c].irq_en;

    cct_channel #(.CW(CW)) u_chan (
      .clk_i   (clk),
      .rst_ni  (rst_ni),
      .mode_i  (mode_q[c]),
      .cnt_i   (cnt),
      .step_i  (cnt_step),
      .pin_i   (cap_in[c]),
      .wr_lo_i (vlo_we),
      .wr_hi_i (vhi_we),
      .wdata_i (bus_wdata),
      .val_o   (ch_val[c]),
      .evt_o   (ch_evt[c]),
      .out_o   (cmp_out[c])
    );
  end

  logic [NSRC-1:0] stat_flags, stat_set, stat_en;
  assign stat_set = {ext_ovf, cnt_ovf, ch_evt};
  assign stat_en  = {ctrl_q[2], ctrl_q[1], ch_ie};

  cct_status #(.NSRC(NSRC)) u_status (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .hw_set_i   (stat_set),
    .clr_we_i   (stat_we),
    .clr_mask_i (NSRC'(bus_wdata)),
    .en_mask_i  (stat_en),
    .flags_o    (stat_flags),
    .irq_o      (irq)
  );

  // read path: mux, then one register stage
  logic [7:0] rd_mux, rdata_q, rdata_d;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(REG_CNT_LO)) rd_mux = cnt[7:0];
    if (bus_addr == AW'(REG_CNT_HI)) rd_mux = 8'(cnt[CW-1:8]);
    if (bus_addr == AW'(REG_CTRL))   rd_mux = 8'(ctrl_q);
    if (bus_addr == AW'(REG_STAT))   rd_mux = 8'(stat_flags);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == AW'(CH_BASE + c * CH_STRIDE + CH_MODE_OFS)) rd_mux = mode_q[c];
      if (bus_addr == AW'(CH_BASE + c * CH_STRIDE + CH_VLO_OFS))  rd_mux = ch_val[c][7:0];
      if (bus_addr == AW'(CH_BASE + c * CH_STRIDE + CH_VHI_OFS))  rd_mux = 8'(ch_val[c][CW-1:8]);
    end
  end
  assign rdata_d = bus_rd ? rd_mux : rdata_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (|stat_flags));

  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_ovf |=> stat_flags[OVF_B]);

  // R10
  ext_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ext_ovf |=> stat_flags[EXT_B]);
endmodule

// File: tb/cctimer_array_test.sv
module cctimer_array_test;
  localparam int NCH = 6;
  localparam logic [5:0] A_CLO = 6'h00, A_CHI = 6'h01, A_CTRL = 6'h02, A_STAT = 6'h03;

  logic           clk = 1'b0;
  logic           rst_n, tick, bus_wr, bus_rd, ext_ovf, irq;
  logic [5:0]     bus_addr;
  logic [7:0]     bus_wdata, bus_rdata;
  logic [NCH-1:0] cap_in, cmp_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  cctimer_array uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_ovf(ext_ovf),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
  );

  function automatic logic [5:0] ch_mode(int c); return 6'(16 + 4*c);     endfunction
  function automatic logic [5:0] ch_vlo(int c);  return 6'(16 + 4*c + 1); endfunction
  function automatic logic [5:0] ch_vhi(int c);  return 6'(16 + 4*c + 2); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] d;
    reg_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic set_cnt(input logic [15:0] v);
    reg_wr(A_CLO, v[7:0]);
    reg_wr(A_CHI, v[15:8]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irq", irq, 0);
    check("R1 cmp_out", cmp_out, 0);
    rd_chk("R1 count lo", A_CLO, 8'h00);
    rd_chk("R1 count hi", A_CHI, 8'h00);
    rd_chk("R1 ctrl", A_CTRL, 8'h00);
    rd_chk("R1 status", A_STAT, 8'h00);
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R1 mode", ch_mode(c), 8'h00);
      rd_chk("R1 value lo", ch_vlo(c), 8'h00);
    end
  endtask

  task automatic t_count;
    reg_wr(A_CTRL, 8'h01);
    rd_chk("R11 ctrl readback", A_CTRL, 8'h01);
    ticks(5);
    rd_chk("R2 five ticks", A_CLO, 8'h05);
    reg_wr(A_CTRL, 8'h00);
    ticks(3);
    rd_chk("R2 halted", A_CLO, 8'h05);
    set_cnt(16'h1234);
    rd_chk("R2 load lo", A_CLO, 8'h34);
    rd_chk("R2 load hi", A_CHI, 8'h12);
  endtask

  task automatic t_overflow;
    reg_wr(A_CTRL, 8'h01);
    set_cnt(16'hFFFE);
    ticks(1);
    rd_chk("R3 no wrap yet", A_STAT, 8'h00);
    ticks(1);
    rd_chk("R3 wrapped lo", A_CLO, 8'h00);
    rd_chk("R3 wrapped hi", A_CHI, 8'h00);
    rd_chk("R3 wrap flag", A_STAT, 8'h40);
    check("R10 wrap irq masked", irq, 0);
    reg_wr(A_CTRL, 8'h03);
    check("R10 wrap irq enabled", irq, 1);
    reg_wr(A_STAT, 8'h00);
    rd_chk("R9 write zero keeps", A_STAT, 8'h40);
    reg_wr(A_STAT, 8'h40);
    rd_chk("R9 write one clears", A_STAT, 8'h00);
    check("R10 irq after clear", irq, 0);
    reg_wr(A_CTRL, 8'h00);
  endtask

  task automatic t_capture;
    set_cnt(16'h1234);
    reg_wr(ch_mode(0), 8'h20);
    @(negedge clk); cap_in[0] = 1'b1;
    idle(4);
    rd_chk("R4 captured lo", ch_vlo(0), 8'h34);
    rd_chk("R4 captured hi", ch_vhi(0), 8'h12);
    rd_chk("R4 flag", A_STAT, 8'h01);
    reg_wr(A_STAT, 8'h01);
    set_cnt(16'h5678);
    @(negedge clk); cap_in[0] = 1'b0;
    idle(4);
    rd_chk("R5 fall ignored value", ch_vlo(0), 8'h34);
    rd_chk("R5 fall ignored flag", A_STAT, 8'h00);
    reg_wr(ch_mode(0), 8'h10);
    @(negedge clk); cap_in[0] = 1'b1;
    idle(4);
    rd_chk("R5 rise ignored flag", A_STAT, 8'h00);
    rd_chk("R5 rise ignored value", ch_vhi(0), 8'h12);
    @(negedge clk); cap_in[0] = 1'b0;
    idle(4);
    rd_chk("R5 fall captured", ch_vhi(0), 8'h56);
    rd_chk("R5 fall flag", A_STAT, 8'h01);
    reg_wr(A_STAT, 8'h01);
    reg_wr(ch_mode(0), 8'h30);
    set_cnt(16'h0101);
    @(negedge clk); cap_in[0] = 1'b1;
    idle(4);
    rd_chk("R5 both rise", ch_vhi(0), 8'h01);
    set_cnt(16'h0202);
    @(negedge clk); cap_in[0] = 1'b0;
    idle(4);
    rd_chk("R5 both fall", ch_vhi(0), 8'h02);
    reg_wr(A_STAT, 8'h01);
    reg_wr(ch_mode(0), 8'h00);
    set_cnt(16'h0303);
    @(negedge clk); cap_in[0] = 1'b1;
    idle(4);
    rd_chk("R5 no capture bits", ch_vhi(0), 8'h02);
    rd_chk("R5 no capture flag", A_STAT, 8'h00);
  endtask

  task automatic t_race;
    reg_wr(ch_mode(1), 8'h30);
    @(negedge clk); cap_in[1] = 1'b1;
    idle(4);
    rd_chk("R9 race setup", A_STAT, 8'h02);
    @(negedge clk); cap_in[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_STAT; bus_wdata = 8'h02; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_chk("R9 set beats clear", A_STAT, 8'h02);
    reg_wr(A_STAT, 8'h02);
    rd_chk("R9 cleared after race", A_STAT, 8'h00);
    reg_wr(ch_mode(1), 8'h00);
  endtask

  task automatic t_compare;
    for (int c = 0; c < 3; c++) begin
      reg_wr(ch_vlo(c), 8'h05);
      reg_wr(ch_vhi(c), 8'h00);
    end
    reg_wr(ch_mode(0), 8'h4C);
    reg_wr(ch_mode(1), 8'h44);
    reg_wr(ch_mode(2), 8'h04);
    set_cnt(16'h0003);
    reg_wr(A_CTRL, 8'h01);
    ticks(1);
    check("R6 no early match", cmp_out[2:0], 3'b000);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R7 not yet toggled", cmp_out[2:0], 3'b000);
    @(negedge clk);
    check("R7 toggled after match", cmp_out[2:0], 3'b011);
    idle(3);
    check("R6 holding is not a match", cmp_out[2:0], 3'b011);
    rd_chk("R6 match flags", A_STAT, 8'h01);
    reg_wr(A_STAT, 8'h01);
    reg_wr(A_CTRL, 8'h00);
    set_cnt(16'h0005);
    idle(2);
    check("R6 load is not a match", cmp_out[2:0], 3'b011);
    rd_chk("R6 load no flag", A_STAT, 8'h00);
    reg_wr(A_CTRL, 8'h01);
    set_cnt(16'h0004);
    ticks(1);
    idle(1);
    check("R7 toggled back", cmp_out[2:0], 3'b000);
    reg_wr(A_STAT, 8'h3F);
    reg_wr(A_CTRL, 8'h00);
    for (int c = 0; c < 3; c++) reg_wr(ch_mode(c), 8'h00);
  endtask

  task automatic t_pwm;
    reg_wr(ch_vlo(3), 8'h40);
    reg_wr(ch_vhi(3), 8'h00);
    reg_wr(ch_mode(3), 8'h01);
    set_cnt(16'h0010);
    check("R8 below", cmp_out[3], 1);
    reg_wr(A_CLO, 8'h3F);
    check("R8 just below", cmp_out[3], 1);
    reg_wr(A_CLO, 8'h40);
    check("R8 equal", cmp_out[3], 0);
    reg_wr(A_CLO, 8'hFF);
    check("R8 above", cmp_out[3], 0);
    set_cnt(16'h7F10);
    check("R8 high byte ignored", cmp_out[3], 1);
    reg_wr(ch_mode(3), 8'h03);
    check("R8 other select", cmp_out[3], 1);
    reg_wr(ch_vlo(3), 8'h00);
    reg_wr(A_CLO, 8'h00);
    check("R8 zero duty", cmp_out[3], 0);
    reg_wr(ch_mode(3), 8'h00);
    reg_wr(A_CLO, 8'h20);
    check("R8 off", cmp_out[3], 0);
  endtask

  task automatic t_irq;
    reg_wr(ch_mode(2), 8'h20);
    @(negedge clk); cap_in[2] = 1'b1;
    idle(4);
    rd_chk("R10 channel flag", A_STAT, 8'h04);
    check("R10 channel masked", irq, 0);
    reg_wr(ch_mode(2), 8'hA0);
    check("R10 channel enabled", irq, 1);
    reg_wr(A_STAT, 8'h04);
    check("R10 enable without flag", irq, 0);
    @(negedge clk); ext_ovf = 1'b1;
    @(negedge clk); ext_ovf = 1'b0;
    rd_chk("R10 ext flag", A_STAT, 8'h80);
    check("R10 ext masked", irq, 0);
    reg_wr(A_CTRL, 8'h04);
    check("R10 ext enabled", irq, 1);
    reg_wr(A_STAT, 8'h80);
    check("R10 ext cleared", irq, 0);
    reg_wr(A_CTRL, 8'h00);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; ext_ovf = 1'b0;
    bus_addr = '0; bus_wdata = '0; cap_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_count();
    t_overflow();
    t_capture();
    t_race();
    t_compare();
    t_pwm();
    t_irq();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule